// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block drives one successive-approximation analog-to-digital conversion. It has a small register bank on a word-addressed bus. Software picks an input channel and switches the converter on with a single control write. The block then counts a programmable settling time in converter ticks. After that it runs a binary search against an external comparator. It stores the right-aligned result, flags completion in the control register, and can raise an interrupt line.

The comparator and the trial DAC are outside the block. The block presents a trial code on `dac_code`. It reads back `cmp_ge`, which is 1 when the analog input is at or above that code. A control write of zero does two things: it acknowledges the interrupt and switches the converter off. If that write arrives during a conversion, it aborts the conversion.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all four registers read 0, `irq` and `adc_power` are 0, and `dac_code` is 0.
- R2: The bus uses word indices 0 to 3: 0 is data (read-only), 1 is status (read-only), 2 is control and 3 is delay. Control bits: [2:0] channel, [3] power, [5] interrupt enable, [6] interrupt status (read-only). Delay uses bits [5:0]. Unused bits read 0. Read data appears on `bus_rdata` one cycle after `bus_rd_en`.
- R3: A control write with power set while idle starts a sequence, and the delay value D is captured. With one converter tick per clock, the interrupt status sets on the (D+RES+2)-th rising edge after the write edge. The first trial code appears after D+1 edges.
- R4: The trials run most-significant bit first. Each trial code is the bits kept so far plus the current bit. A bit is kept when `cmp_ge` is 1. With an ideal comparator, the result is the input clamped to 2^RES-1.
- R5: The data register holds the unsigned result in bits [RES-1:0]. All higher bits read 0.
- R6: Status bit 0 (busy) reads 1 from the starting write until the result is stored, and 0 otherwise.
- R7: Completion sets the interrupt status bit. `irq` equals status AND interrupt enable. `irq` stays high until the next control write.
- R8: A control write of zero clears the interrupt status, the power bit and `irq`.
- R9: A control write with power clear during busy aborts the conversion. Busy clears, no status is set, and the data register keeps its old value.
- R10: During busy, writes to the delay register and to the channel field are ignored. A second control write with power set does not restart or lengthen the conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| cmp_ge | input | 1 | Comparator: input at or above `dac_code` |
| dac_code | output | RES | Trial code for the DAC, 0 outside the bit loop |
| chan_sel | output | 3 | Selected analog channel |
| adc_power | output | 1 | Converter power enable |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit index or a wrong accumulator in the search loop shows up on `dac_code` at the first trial that departs from the expected binary search. It appears within one tick, long before the final result is read. A delay counter that loads or decrements wrongly shifts the interrupt edge by a whole number of cycles, and the cycle-exact latency check catches that shift. A wrong busy-gating decision would accept a channel or delay write, or would corrupt the data register on abort. Either fault is visible in the next register read.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV} seq_state_t;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_DLY  = 2'd3;

  localparam int CHAN_W   = 3;
  localparam int DLY_W    = 6;
  localparam int BIT_PWR  = 3;
  localparam int BIT_IE   = 5;
  localparam int BIT_IST  = 6;
  localparam int BUS_W    = 32;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_full_rate
      logic tick_q;
      always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= 1'b1;
      end
      assign tick = tick_q;
    end else begin : g_divided
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      logic          tick_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else if (cnt_q == CW'(DIV - 1)) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          tick_q <= 1'b0;
        end
      end
      assign tick = tick_q;
    end
  endgenerate
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             abort,
  input  logic [DLY_W-1:0] dly,
  input  logic             cmp_ge,
  output logic             busy,
  output logic             done,
  output logic [RES-1:0]   result,
  output logic [RES-1:0]   dac_code
);
  localparam int IDX_W = (RES > 1) ? $clog2(RES) : 1;

  seq_state_t       state_q;
  logic [DLY_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES-1:0]   acc_q;
  logic             done_q;
  logic [RES-1:0]   trial;

  assign trial = acc_q | ({{(RES-1){1'b0}}, 1'b1} << idx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (start) begin
            state_q <= ST_WAIT;
            cnt_q   <= dly;
          end
          ST_WAIT: if (tick) begin
            if (cnt_q == '0) begin
              state_q <= ST_CONV;
              idx_q   <= IDX_W'(RES - 1);
              acc_q   <= '0;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_CONV: if (tick) begin
            if (cmp_ge) acc_q <= trial;
            if (idx_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy     = (state_q != ST_IDLE) || done_q;
  assign done     = done_q;
  assign result   = acc_q;
  assign dac_code = (state_q == ST_CONV) ? trial : '0;

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_start_idle_R10: assert property (@(posedge clk) disable iff (rst)
    start |-> (state_q == ST_IDLE && !done_q));
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_adc_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [RES-1:0]    result,
  output logic              start,
  output logic              abort,
  output logic [CHAN_W-1:0] chan,
  output logic              pwr,
  output logic              ie,
  output logic              ist,
  output logic [DLY_W-1:0]  dly
);
  logic              ctrl_wr;
  logic              dly_wr;
  logic [RES-1:0]    data_q;
  logic [CHAN_W-1:0] chan_q;
  logic              pwr_q, ie_q, ist_q;
  logic [DLY_W-1:0]  dly_q;
  logic [BUS_W-1:0]  rdata_q;
  logic [BUS_W-1:0]  ctrl_view;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[BUS_W-1:BIT_IST], wdata[4]};

  assign ctrl_wr = wr_en && (addr == REG_CTRL);
  assign dly_wr  = wr_en && (addr == REG_DLY);
  assign start   = ctrl_wr && wdata[BIT_PWR] && !busy;
  assign abort   = ctrl_wr && !wdata[BIT_PWR] && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      chan_q <= '0;
      pwr_q  <= 1'b0;
      ie_q   <= 1'b0;
      ist_q  <= 1'b0;
      dly_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        pwr_q <= wdata[BIT_PWR];
        ie_q  <= wdata[BIT_IE];
        ist_q <= 1'b0;
        if (!busy) chan_q <= wdata[CHAN_W-1:0];
      end
      if (dly_wr && !busy) dly_q <= wdata[DLY_W-1:0];
      if (done) begin
        data_q <= result;
        ist_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CHAN_W-1:0] = chan_q;
    ctrl_view[BIT_PWR]    = pwr_q;
    ctrl_view[BIT_IE]     = ie_q;
    ctrl_view[BIT_IST]    = ist_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (addr)
        REG_DATA: rdata_q <= BUS_W'(data_q);
        REG_STAT: rdata_q <= BUS_W'(busy);
        REG_CTRL: rdata_q <= ctrl_view;
        default:  rdata_q <= BUS_W'(dly_q);
      endcase
    end
  end

  assign rdata = rdata_q;
  assign chan  = chan_q;
  assign pwr   = pwr_q;
  assign ie    = ie_q;
  assign ist   = ist_q;
  assign dly   = dly_q;

  assert_ist_from_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ist_q) |-> $past(done));
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(data_q));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES     = 10,
  parameter int CLK_DIV = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              cmp_ge,
  output logic [RES-1:0]    dac_code,
  output logic [CHAN_W-1:0] chan_sel,
  output logic              adc_power,
  output logic              irq
);
  logic             tick, busy, done, start, abort, pwr, ie, ist;
  logic [RES-1:0]   result;
  logic [DLY_W-1:0] dly;

  sar_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  sar_regs #(.RES(RES)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .busy(busy), .done(done), .result(result),
    .start(start), .abort(abort),
    .chan(chan_sel), .pwr(pwr), .ie(ie), .ist(ist), .dly(dly)
  );

  sar_seq #(.RES(RES)) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .start(start), .abort(abort), .dly(dly), .cmp_ge(cmp_ge),
    .busy(busy), .done(done), .result(result), .dac_code(dac_code)
  );

  assign adc_power = pwr;
  assign irq       = ist & ie;

  assert_busy_powered_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> pwr);
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  localparam int RES = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmp_ge;
  logic [RES-1:0] dac_code;
  logic [2:0]  chan_sel;
  logic        adc_power, irq;
  logic [11:0] vin = '0;
  int          pcyc = 0;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;
  always @(posedge clk) pcyc <= pcyc + 1;

  assign cmp_ge = ({2'b00, dac_code} <= vin);

  sar_adc_ctrl #(.RES(RES)) uut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_ge(cmp_ge), .dac_code(dac_code), .chan_sel(chan_sel),
    .adc_power(adc_power), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int c0, output int lat);
    while (irq !== 1'b1 && (pcyc - c0) < 400) @(negedge clk);
    lat = pcyc - c0;
  endtask

  initial begin
    #2000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int c0, lat;
    logic [RES-1:0] acc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(2'(a), r); chk("R1 reg", r, 0); end
    chk("R1 irq", irq, 0); chk("R1 power", adc_power, 0); chk("R1 dac", dac_code, 0);

    // R2 field map and readback
    wr(2'd2, 32'h0000_0067); rd(2'd2, r); chk("R2 ctrl no status write", r, 32'h27);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, r); chk("R2 delay width", r, 32'h3F);
    wr(2'd0, 32'h0000_FFFF); rd(2'd0, r); chk("R2 data read-only", r, 0);
    wr(2'd1, 32'h0000_0001); rd(2'd1, r); chk("R2 status read-only", r, 0);
    chk("R2 chan out", chan_sel, 7);
    wr(2'd2, 0);

    // R3/R4 trial sequence, MSB first
    vin = 12'd700;
    wr(2'd3, 3);
    wr(2'd2, 32'h2C);
    c0 = pcyc;
    rd(2'd1, r); chk("R6 busy after start", r, 1);
    while (pcyc - c0 < 4) @(negedge clk);
    acc = '0;
    for (int b = RES - 1; b >= 0; b--) begin
      logic [RES-1:0] t;
      t = acc | (RES'(1) << b);
      chk("R4 trial code", dac_code, t);
      if (vin >= {2'b00, t}) acc = t;
      @(negedge clk);
    end
    chk("R3 no irq before store", irq, 0);
    @(negedge clk);
    chk("R3 irq at D+RES+2", irq, 1);
    chk("R3 latency", pcyc - c0, 3 + RES + 2);
    rd(2'd0, r); chk("R4 result 700", r, 700);
    rd(2'd1, r); chk("R6 idle after store", r, 0);
    chk("R2 chan out 4", chan_sel, 4);
    repeat (6) @(negedge clk);
    chk("R7 irq held", irq, 1);
    rd(2'd2, r); chk("R7 status bit", r, 32'h6C);
    wr(2'd2, 0);
    chk("R8 irq cleared", irq, 0); chk("R8 power off", adc_power, 0);
    rd(2'd2, r); chk("R8 ctrl zero", r, 0);

    // R7 interrupt enable off
    vin = 12'd123;
    wr(2'd3, 0); wr(2'd2, 32'h08);
    repeat (20) @(negedge clk);
    chk("R7 irq masked", irq, 0);
    rd(2'd2, r); chk("R7 status set masked", r, 32'h48);
    rd(2'd0, r); chk("R5 result 123", r, 123);
    wr(2'd2, 0);

    // R4/R5 clamp
    vin = 12'd1500;
    wr(2'd2, 32'h28); c0 = pcyc; wait_irq(c0, lat);
    rd(2'd0, r); chk("R5 clamp full scale", r, 1023);
    wr(2'd2, 0);

    // R9 abort
    vin = 12'd300;
    wr(2'd2, 32'h28); c0 = pcyc; wait_irq(c0, lat);
    wr(2'd2, 0);
    vin = 12'd900;
    wr(2'd3, 5); wr(2'd2, 32'h28);
    repeat (8) @(negedge clk);
    wr(2'd2, 0);
    rd(2'd1, r); chk("R9 busy cleared", r, 0);
    repeat (30) @(negedge clk);
    chk("R9 no irq", irq, 0);
    rd(2'd0, r); chk("R9 data kept", r, 300);
    rd(2'd2, r); chk("R9 no status", r, 0);

    // R10 writes ignored while busy
    vin = 12'd555;
    wr(2'd3, 20); wr(2'd2, 32'h2D); c0 = pcyc;
    wr(2'd3, 3); wr(2'd2, 32'h2A);
    rd(2'd2, r); chk("R10 chan held", r, 32'h2D);
    rd(2'd1, r); chk("R6 busy mid", r, 1);
    wait_irq(c0, lat);
    chk("R10 no restart latency", lat, 20 + RES + 2);
    rd(2'd3, r); chk("R10 delay held", r, 20);
    rd(2'd0, r); chk("R10 result", r, 555);
    chk("R10 chan out", chan_sel, 5);
    wr(2'd2, 0);

    // R3/R4/R5 sweep of every input code, delay and channel varied
    for (int v = 0; v < 1024; v++) begin
      vin = 12'(v);
      wr(2'd3, 32'(v % 64));
      wr(2'd2, 32'h28 | 32'(v % 8));
      c0 = pcyc;
      wait_irq(c0, lat);
      chk("R3 sweep latency", lat, (v % 64) + RES + 2);
      rd(2'd0, r); chk("R4 sweep result", r, v);
      wr(2'd2, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule